// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between the two access ports of a two-port memory and the memory array. On every clock edge it samples the chip enable, write strobe and address of the left and right ports. It decides whether the two ports are enabled on the same location at the same time. On a collision it blocks one port by driving that port's active-low busy signal, and it never blocks both. From the same decision it produces one registered write-enable per port for the array. The array itself and any analog setup-time measurement are outside the block.

The port that reaches the shared address later loses. A port counts as arriving in a cycle when it becomes enabled, or changes address while enabled. When both ports arrive in the same cycle, the left port wins. A collision verdict stays in force until the ports stop colliding. Only write enables are ever gated, so reads are untouched.

A static mode input selects master or slave operation. In master mode the block drives both busy outputs from its own verdict, and it gates writes from that verdict alone. In slave mode both busy outputs are held high. The busy levels arriving from an external master on the two busy inputs then gate each port's writes.

Top module: `dp_collision_arb`

## Requirements
- R1: When either enable input is high or the two addresses differ, both busy outputs are high one cycle later.
- R2: In master mode, if the left port was already enabled on an address and the right port newly arrives on that same address, busy_r_n goes low and busy_l_n stays high one cycle later.
- R3: In master mode, if the right port was already enabled on an address and the left port newly arrives on that same address, busy_l_n goes low and busy_r_n stays high one cycle later.
- R4: In master mode, when both ports arrive on the same address in the same cycle, the right port gets busy low and the left port stays high.
- R5: busy_l_n and busy_r_n are never low at the same time.
- R6: A busy verdict is held for as long as the collision persists. It is released one cycle after an address changes or an enable goes high.
- R7: A write request is a low enable together with a low write strobe. In master mode, we_l (we_r) is high one cycle after a write request on that port exactly when the block's own verdict does not make that port busy.
- R8: In slave mode both busy outputs stay high, and a low level on busy_l_in (busy_r_in) blocks the write enable of that port for the request sampled in the same cycle.
- R9: In master mode the busy_l_in and busy_r_in inputs have no effect on the write enables.
- R10: During and after synchronous reset both busy outputs are high and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = slave (busy taken from inputs), 0 = master |
| en_l_n | input | 1 | Left port enable, active low |
| wr_l_n | input | 1 | Left port write strobe, active low |
| addr_l | input | ADDR_W | Left port address |
| en_r_n | input | 1 | Right port enable, active low |
| wr_r_n | input | 1 | Right port write strobe, active low |
| addr_r | input | ADDR_W | Right port address |
| busy_l_in | input | 1 | External busy for the left port (slave mode), active low |
| busy_r_in | input | 1 | External busy for the right port (slave mode), active low |
| busy_l_n | output | 1 | Left port busy, active low |
| busy_r_n | output | 1 | Right port busy, active low |
| we_l | output | 1 | Registered write enable for the left port into the array |
| we_r | output | 1 | Registered write enable for the right port into the array |

## Verification
The bench approaches a shared address in three orders: left first, right first, and both in the same cycle. These tell apart a correct later-loses rule from a fixed priority or a reversed winner. Near-miss patterns follow: differing addresses, and a matching address with one port disabled. They separate a true match detector from one that ignores enables or compares too few bits. A long hold followed by a single address step shows whether the verdict is sticky and releases in time. Identical write patterns run with the busy inputs pulled low in master mode and in slave mode. They separate the internal verdict from the pin level as the source of write blocking.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int NUM_SIDES = 2;
  typedef logic [NUM_SIDES-1:0] side_mask_t;
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              arrive
);
  logic              prev_act_q;
  logic [ADDR_W-1:0] prev_addr_q;

  assign active = !en_n;
  assign arrive = active && (!prev_act_q || (prev_addr_q != addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_act_q  <= active;
      prev_addr_q <= addr;
    end
  end
endmodule

// File: rtl/dpca_decide.sv
module dpca_decide
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  side_mask_t        active,
  input  side_mask_t        arrive,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  side_mask_t        lose_q,
  output side_mask_t        lose_nxt
);
  logic collide;
  assign collide = active[SIDE_L] && active[SIDE_R] && (addr_l == addr_r);

  always_comb begin
    lose_nxt = '0;
    if (collide) begin
      if (lose_q != '0) begin
        lose_nxt = lose_q;
      end else if (arrive[SIDE_L] && !arrive[SIDE_R]) begin
        lose_nxt[SIDE_L] = 1'b1;
      end else begin
        lose_nxt[SIDE_R] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slave_mode,
  input  logic              en_l_n,
  input  logic              wr_l_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              en_r_n,
  input  logic              wr_r_n,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              busy_l_in,
  input  logic              busy_r_in,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              we_l,
  output logic              we_r
);
  logic [ADDR_W-1:0] addr_v [NUM_SIDES];
  side_mask_t en_n_v, wr_n_v, ext_busy_n, active, arrive;
  side_mask_t lose_q, lose_nxt, we_q;

  assign addr_v[SIDE_L]     = addr_l;
  assign addr_v[SIDE_R]     = addr_r;
  assign en_n_v             = {en_r_n, en_l_n};
  assign wr_n_v             = {wr_r_n, wr_l_n};
  assign ext_busy_n         = {busy_r_in, busy_l_in};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic blocked;

    dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk    (clk),
      .rst    (rst),
      .en_n   (en_n_v[s]),
      .addr   (addr_v[s]),
      .active (active[s]),
      .arrive (arrive[s])
    );

    assign blocked = slave_mode ? !ext_busy_n[s] : lose_nxt[s];

    always_ff @(posedge clk) begin
      if (rst) we_q[s] <= 1'b0;
      else     we_q[s] <= !en_n_v[s] && !wr_n_v[s] && !blocked;
    end
  end

  dpca_decide #(.ADDR_W(ADDR_W)) u_decide (
    .active   (active),
    .arrive   (arrive),
    .addr_l   (addr_l),
    .addr_r   (addr_r),
    .lose_q   (lose_q),
    .lose_nxt (lose_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) lose_q <= '0;
    else     lose_q <= lose_nxt;
  end

  assign busy_l_n = slave_mode || !lose_q[SIDE_L];
  assign busy_r_n = slave_mode || !lose_q[SIDE_R];
  assign we_l     = we_q[SIDE_L];
  assign we_r     = we_q[SIDE_R];
endmodule

// File: rtl/dpca_checker.sv
module dpca_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              slave_mode,
  input logic              en_l_n,
  input logic              en_r_n,
  input logic [ADDR_W-1:0] addr_l,
  input logic [ADDR_W-1:0] addr_r,
  input logic              busy_l_n,
  input logic              busy_r_n,
  input logic              we_l,
  input logic              we_r
);
  logic match_in;
  assign match_in = !en_l_n && !en_r_n && (addr_l == addr_r);

  // R5
  a_r5_never_both_low: assert property (@(posedge clk) disable iff (rst)
    !(!busy_l_n && !busy_r_n));

  // R1
  a_r1_release_no_match: assert property (@(posedge clk) disable iff (rst)
    !match_in |=> (busy_l_n && busy_r_n));

  // R7
  a_r7_left_busy_no_write: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && !busy_l_n) |-> !we_l);
  a_r7_right_busy_no_write: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && !busy_r_n) |-> !we_r);

  // R6
  a_r6_hold_right: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && $stable(slave_mode) && !busy_r_n && match_in) |=> !busy_r_n);
  a_r6_hold_left: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && $stable(slave_mode) && !busy_l_n && match_in) |=> !busy_l_n);

  // R8
  a_r8_slave_busy_high: assert property (@(posedge clk) disable iff (rst)
    slave_mode |-> (busy_l_n && busy_r_n));
endmodule

bind dp_collision_arb dpca_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .slave_mode(slave_mode),
  .en_l_n(en_l_n), .en_r_n(en_r_n), .addr_l(addr_l), .addr_r(addr_r),
  .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .we_l(we_l), .we_r(we_r)
);

// File: tb/sim_dp_collision_arb.sv
`timescale 1ns/1ps
module sim_dp_collision_arb;
  localparam int AW = 13;
  logic clk = 0, rst = 1, slave_mode = 0;
  logic en_l_n = 1, wr_l_n = 1, en_r_n = 1, wr_r_n = 1;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic busy_l_in = 1, busy_r_in = 1;
  logic busy_l_n, busy_r_n, we_l, we_r;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .en_l_n(en_l_n), .wr_l_n(wr_l_n), .addr_l(addr_l),
    .en_r_n(en_r_n), .wr_r_n(wr_r_n), .addr_r(addr_r),
    .busy_l_in(busy_l_in), .busy_r_in(busy_r_in),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .we_l(we_l), .we_r(we_r)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {busy_l_n, busy_r_n, we_l, we_r};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {busy_l_n,busy_r_n,we_l,we_r} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    en_l_n = 1; en_r_n = 1; wr_l_n = 1; wr_r_n = 1;
    busy_l_in = 1; busy_r_in = 1;
    step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R10", 4'b1100);
    rst = 0; idle();
    chk("R10", 4'b1100);
  endtask

  task automatic t_no_collision();
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h005;
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h006;
    step(); chk("R1", 4'b1111);
    addr_r = 13'h005; en_r_n = 1; step();
    chk("R1", 4'b1110);
    addr_r = 13'h1005; en_r_n = 0; step();
    chk("R1", 4'b1111);
    idle();
  endtask

  task automatic t_left_first();
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h009; step();
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h009; step();
    chk("R2", 4'b1010);
    for (int i = 0; i < 3; i++) begin
      step(); chk("R6", 4'b1010);
    end
    addr_r = 13'h00A; step();
    chk("R6", 4'b1111);
    idle();
  endtask

  task automatic t_right_first();
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h1FFF; step();
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h1FFF; step();
    chk("R3", 4'b0101);
    step(); chk("R6", 4'b0101);
    en_r_n = 1; step();
    chk("R6", 4'b1110);
    idle();
  endtask

  task automatic t_simultaneous();
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h003;
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h003;
    step(); chk("R4", 4'b1010);
    wr_l_n = 1; step(); chk("R5", 4'b1000);
    idle();
  endtask

  task automatic t_master_ignores_pins();
    busy_l_in = 0; busy_r_in = 0;
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h011;
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h012;
    step(); chk("R9", 4'b1111);
    idle();
  endtask

  task automatic t_slave();
    slave_mode = 1; step();
    en_l_n = 0; wr_l_n = 0; addr_l = 13'h020;
    en_r_n = 0; wr_r_n = 0; addr_r = 13'h020;
    busy_l_in = 0; busy_r_in = 1;
    step(); chk("R8", 4'b1101);
    busy_l_in = 1; busy_r_in = 1;
    step(); chk("R8", 4'b1111);
    busy_r_in = 0; step(); chk("R8", 4'b1110);
    idle();
    slave_mode = 0; idle();
  endtask

  initial begin
    t_reset();
    t_no_collision();
    t_left_first();
    t_right_first();
    t_simultaneous();
    t_master_ignores_pins();
    t_slave();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule